// File: doc/BRIEF.md
# Mesh Router Output Port Selector

This block is the routing stage of one node in a two-dimensional mesh network-on-chip. It accepts one flit at a time from an input buffer that has already won arbitration. It reads the destination coordinates from the flit header and compares them with the node's own coordinates. From that comparison it picks one of five output ports: the four compass directions and a local port toward the network interface. It does no arbitration or storage of its own.

The chosen port goes to a separate scheduler on a valid-qualified code. The flit is held until the scheduler confirms that the path is free. On the cycle after confirmation the flit goes out with its port tag, and the block is ready for the next flit.

The routing order can be switched at run time:
- X-first resolves the column before the row.
- Y-first resolves the row before the column.
- Random picks one of those two orders per flit from a free-running pseudo-random bit.

The order is fixed when a flit is accepted and holds until that flit leaves.

Top module: `mesh_port_selector`

## Requirements
- R1: While reset is high and on the first cycle after it, `port_valid` and `out_valid` are 0 and `in_ready` is 1.
- R2: The flit is packed from the most significant bit down as follows: priority (PRIO_W bits), timestamp (TS_W bits), source X, source Y, destination X, destination Y (COORD_W bits each), then payload (PAY_W bits). Only the destination fields affect routing. Port codes are 0 local, 1 north (destination Y greater), 2 south (destination Y smaller), 3 east (destination X greater) and 4 west (destination X smaller).
- R3: When the destination X and Y both equal `node_x` and `node_y`, the selected port is local (0) in every mode.
- R4: With `route_mode` 0 (X-first), or the reserved value 3, a differing X selects east or west. Otherwise a differing Y selects north or south.
- R5: With `route_mode` 1 (Y-first), a differing Y selects north or south. Otherwise a differing X selects east or west.
- R6: With `route_mode` 2 (random), the port is always one that either fixed order would give. When only one axis differs, that axis's direction is chosen. Over many flits that differ on both axes, both orders occur.
- R7: A flit is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `port_valid` is 1 and `port_code` stays constant until a cycle in which `port_confirm` is 1. While unconfirmed, nothing is forwarded.
- R8: One cycle after `port_confirm` is sampled with `port_valid`, `out_valid` is 1 for exactly one cycle. In that cycle `out_flit` equals the accepted flit bit for bit and `out_port` equals the reported code.
- R9: `in_ready` is 0 from acceptance until the cycle after the forwarding pulse. A flit offered in that window is not taken and does not disturb the pending one.
- R10: Changing `route_mode`, `node_x` or `node_y` while a flit is pending does not change its port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| route_mode | input | 2 | Routing order: 0 X-first, 1 Y-first, 2 random, 3 treated as X-first |
| node_x | input | COORD_W | Column of this node |
| node_y | input | COORD_W | Row of this node |
| in_valid | input | 1 | A granted flit is offered |
| in_flit | input | FLIT_W | Offered flit |
| in_ready | output | 1 | Block can take a flit |
| port_valid | output | 1 | A port request is pending toward the scheduler |
| port_code | output | 3 | Requested output port |
| port_confirm | input | 1 | Scheduler confirms that the requested path is free |
| out_valid | output | 1 | Forwarded flit is valid this cycle |
| out_port | output | 3 | Port the forwarded flit belongs to |
| out_flit | output | FLIT_W | Forwarded flit |

## Verification
The bench builds the block with 3-bit coordinates, which models an 8 by 8 mesh. This allows nodes and destinations at both edges, 0 and 7, where an off-by-one in the comparison or a signed slip would show. The source fields are filled with the bit-inverse of the destination so that a decode of the wrong header field gives a wrong port. The 8-bit pseudo-random generator gives a period long enough for a few dozen random-mode flits to show both orders.

// File: rtl/mesh_sel_pkg.sv
package mesh_sel_pkg;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_NORTH = 3'd1,
        PORT_SOUTH = 3'd2,
        PORT_EAST  = 3'd3,
        PORT_WEST  = 3'd4
    } port_e;

    typedef enum logic [1:0] {
        MODE_XFIRST = 2'd0,
        MODE_YFIRST = 2'd1,
        MODE_RANDOM = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_SEND = 2'd2
    } sel_state_e;

    // Relation of destination to this node along both axes.
    typedef struct packed {
        logic x_gt;
        logic x_lt;
        logic y_gt;
        logic y_lt;
    } axis_cmp_t;

    // Dimension-ordered decision for one order.
    function automatic port_e route_dir(input axis_cmp_t c, input logic y_first);
        port_e p;
        p = PORT_LOCAL;
        if (y_first) begin
            if (c.y_gt)      p = PORT_NORTH;
            else if (c.y_lt) p = PORT_SOUTH;
            else if (c.x_gt) p = PORT_EAST;
            else if (c.x_lt) p = PORT_WEST;
        end else begin
            if (c.x_gt)      p = PORT_EAST;
            else if (c.x_lt) p = PORT_WEST;
            else if (c.y_gt) p = PORT_NORTH;
            else if (c.y_lt) p = PORT_SOUTH;
        end
        return p;
    endfunction

endpackage

// File: rtl/mesh_order_lfsr.sv
module mesh_order_lfsr #(
    parameter int          LFSR_W = 8,
    parameter logic [LFSR_W-1:0] TAPS = 8'hB8,
    parameter logic [LFSR_W-1:0] SEED = 8'h5A
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic order_bit
);
    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (step) begin
            if (state_q[0]) state_q <= (state_q >> 1) ^ TAPS;
            else            state_q <= state_q >> 1;
        end
    end

    assign order_bit = state_q[0];

    // R6: the generator must never lock up in the all-zero state
    a_r6_lfsr_alive: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

endmodule

// File: rtl/mesh_route_calc.sv
module mesh_route_calc
    import mesh_sel_pkg::*;
#(
    parameter int COORD_W = 3
) (
    input  logic [COORD_W-1:0] here_x,
    input  logic [COORD_W-1:0] here_y,
    input  logic [COORD_W-1:0] dest_x,
    input  logic [COORD_W-1:0] dest_y,
    input  logic               y_first,
    output port_e              port
);
    axis_cmp_t cmp;
    port_e     by_order [2];

    always_comb begin
        cmp.x_gt = dest_x > here_x;
        cmp.x_lt = dest_x < here_x;
        cmp.y_gt = dest_y > here_y;
        cmp.y_lt = dest_y < here_y;
    end

    // One decision per dimension order, computed in parallel.
    for (genvar g = 0; g < 2; g++) begin : g_order
        assign by_order[g] = route_dir(cmp, (g == 1));
    end

    assign port = y_first ? by_order[1] : by_order[0];

endmodule

// File: rtl/mesh_port_selector.sv
module mesh_port_selector
    import mesh_sel_pkg::*;
#(
    parameter int COORD_W = 3,
    parameter int PRIO_W  = 2,
    parameter int TS_W    = 8,
    parameter int PAY_W   = 16,
    parameter int LFSR_W  = 8,
    localparam int FLIT_W = PRIO_W + TS_W + 4 * COORD_W + PAY_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         route_mode,
    input  logic [COORD_W-1:0] node_x,
    input  logic [COORD_W-1:0] node_y,
    input  logic               in_valid,
    input  logic [FLIT_W-1:0]  in_flit,
    output logic               in_ready,
    output logic               port_valid,
    output logic [2:0]         port_code,
    input  logic               port_confirm,
    output logic               out_valid,
    output logic [2:0]         out_port,
    output logic [FLIT_W-1:0]  out_flit
);
    // Header field positions, counted from the payload upward.
    localparam int DY_LSB = PAY_W;
    localparam int DX_LSB = DY_LSB + COORD_W;

    sel_state_e          st_q;
    logic [FLIT_W-1:0]   flit_q;
    port_e               port_q;
    port_e               port_calc;
    logic                take;
    logic                rnd_bit;
    logic                use_y_first;
    logic [COORD_W-1:0]  hdr_dx;
    logic [COORD_W-1:0]  hdr_dy;

    assign in_ready = (st_q == ST_IDLE);
    assign take     = in_valid && in_ready;
    assign hdr_dx   = in_flit[DX_LSB +: COORD_W];
    assign hdr_dy   = in_flit[DY_LSB +: COORD_W];

    mesh_order_lfsr #(
        .LFSR_W (LFSR_W),
        .TAPS   (LFSR_W'(8'hB8)),
        .SEED   (LFSR_W'(8'h5A))
    ) i_lfsr (
        .clk       (clk),
        .rst       (rst),
        .step      (take),
        .order_bit (rnd_bit)
    );

    always_comb begin
        unique case (route_mode)
            MODE_YFIRST: use_y_first = 1'b1;
            MODE_RANDOM: use_y_first = rnd_bit;
            default:     use_y_first = 1'b0;
        endcase
    end

    mesh_route_calc #(
        .COORD_W (COORD_W)
    ) i_calc (
        .here_x  (node_x),
        .here_y  (node_y),
        .dest_x  (hdr_dx),
        .dest_y  (hdr_dy),
        .y_first (use_y_first),
        .port    (port_calc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            flit_q <= '0;
            port_q <= PORT_LOCAL;
        end else begin
            unique case (st_q)
                ST_IDLE: if (take) begin
                    flit_q <= in_flit;
                    port_q <= port_calc;
                    st_q   <= ST_REQ;
                end
                ST_REQ:  if (port_confirm) st_q <= ST_SEND;
                ST_SEND: st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign port_valid = (st_q == ST_REQ);
    assign port_code  = port_q;
    assign out_valid  = (st_q == ST_SEND);
    assign out_port   = port_q;
    assign out_flit   = flit_q;

    // R1: quiet and ready right after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!port_valid && !out_valid && in_ready));

    // R2: only the five defined codes reach the scheduler
    a_r2_code_range: assert property (@(posedge clk) disable iff (rst)
        port_valid |-> (port_code <= 3'd4));

    // R7: a pending request holds its code until confirmed
    a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
        (port_valid && !port_confirm) |=> (port_valid && $stable(port_code) && !out_valid));

    // R8: forwarding only follows a confirmed request
    a_r8_after_confirm: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(port_valid && port_confirm));

    // R8: forwarded tag equals the code the scheduler saw
    a_r8_tag_match: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_port == $past(port_code)));

    // R8: single-cycle forwarding pulse
    a_r8_one_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R9: no new flit taken while one is pending or leaving
    a_r9_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        (port_valid || out_valid) |-> !in_ready);

endmodule

// File: tb/test_mesh_port_selector.sv
module test_mesh_port_selector;
    localparam int CLK_PERIOD = 10;
    localparam int CW   = 3;
    localparam int PW   = 2;
    localparam int TW   = 8;
    localparam int DW   = 16;
    localparam int FW   = PW + TW + 4 * CW + DW;
    localparam int NVEC = 13;

    // {mode, node_x, node_y, dest_x, dest_y, expected port}
    localparam logic [16:0] VEC [NVEC] = '{
        {2'd0, 3'd3, 3'd3, 3'd3, 3'd3, 3'd0},   // R3
        {2'd0, 3'd3, 3'd3, 3'd5, 3'd6, 3'd3},   // R4 east first
        {2'd0, 3'd3, 3'd3, 3'd1, 3'd0, 3'd4},   // R4 west first
        {2'd0, 3'd3, 3'd3, 3'd3, 3'd7, 3'd1},   // R4 x aligned -> north
        {2'd0, 3'd3, 3'd3, 3'd3, 3'd0, 3'd2},   // R4 x aligned -> south
        {2'd1, 3'd3, 3'd3, 3'd5, 3'd6, 3'd1},   // R5 north first
        {2'd1, 3'd3, 3'd3, 3'd1, 3'd0, 3'd2},   // R5 south first
        {2'd1, 3'd3, 3'd3, 3'd6, 3'd3, 3'd3},   // R5 y aligned -> east
        {2'd1, 3'd0, 3'd0, 3'd7, 3'd7, 3'd1},   // R5 corner to corner
        {2'd3, 3'd4, 3'd2, 3'd0, 3'd7, 3'd4},   // R4 reserved mode
        {2'd1, 3'd7, 3'd7, 3'd7, 3'd7, 3'd0},   // R3 at edge
        {2'd2, 3'd2, 3'd2, 3'd2, 3'd5, 3'd1},   // R6 single axis
        {2'd2, 3'd2, 3'd2, 3'd0, 3'd2, 3'd4}    // R6 single axis
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    route_mode = '0;
    logic [CW-1:0] node_x = '0;
    logic [CW-1:0] node_y = '0;
    logic          in_valid = 1'b0;
    logic [FW-1:0] in_flit = '0;
    logic          in_ready;
    logic          port_valid;
    logic [2:0]    port_code;
    logic          port_confirm = 1'b0;
    logic          out_valid;
    logic [2:0]    out_port;
    logic [FW-1:0] out_flit;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mesh_port_selector #(
        .COORD_W (CW), .PRIO_W (PW), .TS_W (TW), .PAY_W (DW), .LFSR_W (8)
    ) i_mesh_port_selector (
        .clk (clk), .rst (rst), .route_mode (route_mode),
        .node_x (node_x), .node_y (node_y),
        .in_valid (in_valid), .in_flit (in_flit), .in_ready (in_ready),
        .port_valid (port_valid), .port_code (port_code), .port_confirm (port_confirm),
        .out_valid (out_valid), .out_port (out_port), .out_flit (out_flit)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Source fields carry the inverse of the destination to expose a wrong field decode.
    function automatic logic [FW-1:0] mk_flit(input logic [CW-1:0] dx, input logic [CW-1:0] dy,
                                              input logic [DW-1:0] pay);
        return {2'b01, 8'hC3, ~dx, ~dy, dx, dy, pay};
    endfunction

    // Offers one flit, waits dly cycles before confirming, checks request and forward.
    task automatic run_flit(input logic [1:0] m, input logic [CW-1:0] nx, input logic [CW-1:0] ny,
                            input logic [CW-1:0] dx, input logic [CW-1:0] dy,
                            input logic [DW-1:0] pay, input bit chk_port, input logic [2:0] exp,
                            input int dly, input string req, output logic [2:0] got);
        logic [FW-1:0] f;
        f = mk_flit(dx, dy, pay);
        @(negedge clk);
        route_mode = m; node_x = nx; node_y = ny;
        in_flit = f; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        got = port_code;
        check(port_valid === 1'b1, {req, " R7 request raised"}, 64'(port_valid), 64'd1);
        if (chk_port) check(port_code === exp, {req, " port code"}, 64'(port_code), 64'(exp));
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            check(port_valid === 1'b1 && port_code === got && out_valid === 1'b0,
                  {req, " R7 hold without confirm"}, 64'(port_code), 64'(got));
        end
        port_confirm = 1'b1;
        @(negedge clk);
        port_confirm = 1'b0;
        check(out_valid === 1'b1 && out_port === got, {req, " R8 forward tag"}, 64'(out_port), 64'(got));
        check(out_flit === f, {req, " R8 flit intact"}, 64'(out_flit), 64'(f));
        @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b1, {req, " R8 single pulse"}, 64'(out_valid), 64'd0);
    endtask

    initial begin
        logic [2:0] got;
        int n_x, n_y;
        logic [FW-1:0] fa, fb;

        // R1 reset
        repeat (3) @(negedge clk);
        check(port_valid === 1'b0 && out_valid === 1'b0 && in_ready === 1'b1,
              "R1 during reset", {61'd0, port_valid, out_valid, in_ready}, 64'd1);
        rst = 1'b0;
        @(negedge clk);
        check(port_valid === 1'b0 && out_valid === 1'b0 && in_ready === 1'b1,
              "R1 after reset", {61'd0, port_valid, out_valid, in_ready}, 64'd1);

        // R2 R3 R4 R5 R6 table walk
        for (int i = 0; i < NVEC; i++) begin
            run_flit(VEC[i][16:15], VEC[i][14:12], VEC[i][11:9], VEC[i][8:6], VEC[i][5:3],
                     16'hA000 + 16'(i), 1'b1, VEC[i][2:0], i % 3, $sformatf("R2 vec%0d", i), got);
        end

        // R6 random order over both axes
        n_x = 0; n_y = 0;
        for (int i = 0; i < 32; i++) begin
            run_flit(2'd2, 3'd2, 3'd2, 3'd5, 3'd6, 16'hB000 + 16'(i), 1'b0, 3'd0, 0, "R6 random", got);
            check(got == 3'd3 || got == 3'd1, "R6 random port in set", 64'(got), 64'd3);
            if (got == 3'd3) n_x++;
            if (got == 3'd1) n_y++;
        end
        check(n_x > 0 && n_y > 0, "R6 both orders seen", 64'(n_x), 64'(n_y));

        // R10 mode and coordinates change while pending
        fa = mk_flit(3'd5, 3'd6, 16'hC0DE);
        @(negedge clk);
        route_mode = 2'd0; node_x = 3'd3; node_y = 3'd3; in_flit = fa; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        route_mode = 2'd1; node_x = 3'd6; node_y = 3'd0;
        repeat (2) @(negedge clk);
        check(port_valid === 1'b1 && port_code === 3'd3, "R10 held port", 64'(port_code), 64'd3);
        port_confirm = 1'b1;
        @(negedge clk);
        port_confirm = 1'b0;
        check(out_valid === 1'b1 && out_port === 3'd3, "R10 forwarded port", 64'(out_port), 64'd3);
        @(negedge clk);

        // R9 second offer while busy is not taken
        fa = mk_flit(3'd0, 3'd3, 16'h1111);
        fb = mk_flit(3'd3, 3'd0, 16'h2222);
        route_mode = 2'd0; node_x = 3'd3; node_y = 3'd3;
        @(negedge clk);
        in_flit = fa; in_valid = 1'b1;
        @(negedge clk);
        in_flit = fb;
        check(in_ready === 1'b0, "R9 not ready while pending", 64'(in_ready), 64'd0);
        @(negedge clk);
        check(port_code === 3'd4, "R9 pending port undisturbed", 64'(port_code), 64'd4);
        port_confirm = 1'b1;
        @(negedge clk);
        port_confirm = 1'b0;
        check(out_valid === 1'b1 && out_flit === fa, "R9 first flit forwarded", 64'(out_flit), 64'(fa));
        check(in_ready === 1'b0, "R9 not ready during forward", 64'(in_ready), 64'd0);
        @(negedge clk);
        check(in_ready === 1'b1, "R9 ready after forward", 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        check(port_valid === 1'b1 && port_code === 3'd2, "R9 second flit south", 64'(port_code), 64'd2);
        port_confirm = 1'b1;
        @(negedge clk);
        port_confirm = 1'b0;
        check(out_valid === 1'b1 && out_flit === fb, "R9 second flit forwarded", 64'(out_flit), 64'(fb));
        @(negedge clk);

        // R1 reset while pending drops the request
        @(negedge clk);
        in_flit = fa; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(port_valid === 1'b0 && in_ready === 1'b1, "R1 reset clears pending", 64'(port_valid), 64'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule